// File: doc/BRIEF.md
# Dual-button long-press reset generator

This block turns a deliberate two-button long press into a hard system reset. Two active-low button inputs are synchronised. A reset is qualified only after both buttons have been held low together, without a break, for a setup time. A two-bit strap code picks the setup time: short, middle or long. Once the press qualifies, the block drives two reset outputs of opposite polarity. Each output has its own pulse length. The first length comes from an input port. The second is fixed when the block is built, with a choice of two values.

A digital undervoltage flag forces both outputs active for as long as it is high. After the flag clears, each output stays active for its own pulse length. Leaving reset at power-on behaves the same way. The first output enforces a quiet gap after each pulse. A request that arrives during the gap is held and served when the gap ends.

All durations are counted in milliseconds of a tick derived from the system clock. A testbench can therefore shrink every time by changing the clock and tick frequency parameters.

Top module: `lpress_rst_gen`

## Requirements
- R1: A reset starts only after both synchronised buttons have been low together for the selected number of milliseconds without interruption. Any release clears the count, so two short presses never add up.
- R2: The setup time is selected by `delay_sel`: 2'b00 selects SETUP_SHORT_MS, 2'b01 selects SETUP_MID_MS, and 2'b10 or 2'b11 select SETUP_LONG_MS. The code is captured while `rst_n` is low and held for as long as reset stays released.
- R3: When both outputs are idle, a qualified press asserts both outputs in the same clock cycle.
- R4: `rst_hi` is active-high and `rst_lo_n` is active-low.
- R5: After a trigger, `rst_hi` stays active for `pulse1_len` milliseconds, with 0 treated as 1. `rst_lo_n` stays active for OUT2_SHORT_MS, or for OUT2_LONG_MS when OUT2_LONG is 1.
- R6: While `uv_flag` is high, both outputs are active from the next cycle. After `uv_flag` falls, each output stays active for its own pulse length and then releases.
- R7: Both outputs are active while `rst_n` is low. After `rst_n` is released, each output stays active for its own pulse length.
- R8: With one button input tied low, the other button alone qualifies a long press.
- R9: After a `rst_hi` pulse ends, `rst_hi` stays inactive for GAP_MS milliseconds. A trigger that arrives in that gap is held and starts `rst_hi` when the gap expires. `rst_lo_n` is not held back by this gap.
- R10: One millisecond equals CLK_HZ/TICK_HZ clock cycles. Every duration is a whole number of these ticks.
- R11: After a qualified press, no new press is counted until the button pair has left the both-low state. A button pair that stays held therefore yields a single reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; also treated as power-on |
| btn_a_n | input | 1 | First push-button, active-low, asynchronous |
| btn_b_n | input | 1 | Second push-button, active-low, asynchronous |
| delay_sel | input | 2 | Setup-time strap code, captured during reset |
| uv_flag | input | 1 | Undervoltage indication, active-high |
| pulse1_len | input | P1W | Pulse length of `rst_hi` in milliseconds |
| rst_hi | output | 1 | First reset output, active-high |
| rst_lo_n | output | 1 | Second reset output, active-low |

## Verification
The bench builds the block with CLK_HZ=4000 and TICK_HZ=1000, so one millisecond is four cycles. The setup times are set to 8, 12 and 16 ms, the fixed second pulse to 5 ms, and the quiet gap to 20 ms. With these values every setup time, pulse and gap fits into a few hundred cycles. The gap is made longer than the short setup time, so a second qualified press lands inside the gap of the first output. This makes the hold-off and its release observable at the ports. Each timing is checked against a window of one tick, because the tick phase at the moment a press begins is not aligned to the press.

// File: rtl/lpress_pkg.sv
package lpress_pkg;

  typedef enum logic [1:0] {
    SP_IDLE   = 2'd0,
    SP_ACTIVE = 2'd1,
    SP_GAP    = 2'd2
  } stretch_state_e;

  // strap code to setup length in milliseconds
  function automatic int unsigned pick_setup(input logic [1:0] code,
                                             input int unsigned short_ms,
                                             input int unsigned mid_ms,
                                             input int unsigned long_ms);
    if (code[1])      return long_ms;
    else if (code[0]) return mid_ms;
    else              return short_ms;
  endfunction

  // true on the tick that completes a span of len ticks (len 0 acts as 1)
  function automatic logic span_done(input int unsigned cnt, input int unsigned len);
    return (cnt + 1 >= len);
  endfunction

  function automatic int unsigned maxu(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lpr_tick.sv
module lpr_tick #(
  parameter int unsigned DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == CW'(DIV - 1));
      if (cnt == CW'(DIV - 1)) cnt <= '0;
      else                     cnt <= cnt + 1'b1;
    end
  end

  generate
    if (DIV > 1) begin : g_spacing
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R10
    end
  endgenerate

endmodule

// File: rtl/lpr_qualify.sv
module lpr_qualify
  import lpress_pkg::*;
#(
  parameter int unsigned CW       = 16,
  parameter int unsigned SHORT_MS = 2500,
  parameter int unsigned MID_MS   = 7500,
  parameter int unsigned LONG_MS  = 12500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       btn_a_n,
  input  logic       btn_b_n,
  input  logic [1:0] sel_code,
  output logic       fire
);
  logic [1:0]    sync_a, sync_b;
  logic          pressed;
  logic          armed;
  logic [CW-1:0] hold_cnt;
  int unsigned   target;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 2'b11;
      sync_b <= 2'b11;
    end else begin
      sync_a <= {sync_a[0], btn_a_n};
      sync_b <= {sync_b[0], btn_b_n};
    end
  end

  assign pressed = !sync_a[1] && !sync_b[1];
  assign target  = pick_setup(sel_code, SHORT_MS, MID_MS, LONG_MS);
  assign fire    = pressed && armed && tick && span_done(32'(hold_cnt), target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      hold_cnt <= '0;
    end else if (!pressed) begin
      armed    <= 1'b1;
      hold_cnt <= '0;
    end else if (fire) begin
      armed    <= 1'b0;
      hold_cnt <= '0;
    end else if (tick && armed) begin
      hold_cnt <= hold_cnt + 1'b1;
    end
  end

  AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed); // R11
  AST_REARM_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(!pressed)); // R11

endmodule

// File: rtl/lpr_stretch.sv
module lpr_stretch
  import lpress_pkg::*;
#(
  parameter int unsigned CW     = 16,
  parameter int unsigned GAP_MS = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          hold,
  input  logic          trig,
  input  logic [CW-1:0] len,
  output logic          act,
  output logic          idle
);
  stretch_state_e state;
  logic [CW-1:0]  cnt;
  logic           pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SP_ACTIVE;
      cnt   <= '0;
      pend  <= 1'b0;
    end else if (hold) begin
      state <= SP_ACTIVE;
      cnt   <= '0;
      pend  <= 1'b0;
    end else begin
      case (state)
        SP_IDLE: begin
          if (trig || pend) begin
            state <= SP_ACTIVE;
            cnt   <= '0;
            pend  <= 1'b0;
          end
        end
        SP_ACTIVE: begin
          if (tick) begin
            if (span_done(32'(cnt), 32'(len))) begin
              cnt <= '0;
              if (GAP_MS > 0) state <= SP_GAP;
              else            state <= SP_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        SP_GAP: begin
          if (trig) pend <= 1'b1;
          if (tick) begin
            if (span_done(32'(cnt), GAP_MS)) begin
              cnt   <= '0;
              state <= SP_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= SP_IDLE;
      endcase
    end
  end

  assign act  = (state == SP_ACTIVE);
  assign idle = (state == SP_IDLE);

  AST_HOLD_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> act); // R6

  generate
    if (GAP_MS > 0) begin : g_gap_chk
      AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(act) && !hold) |=> !act); // R9
    end
  endgenerate

endmodule

// File: rtl/lpress_rst_gen.sv
module lpress_rst_gen
  import lpress_pkg::*;
#(
  parameter int unsigned CLK_HZ         = 50000000,
  parameter int unsigned TICK_HZ        = 1000,
  parameter int unsigned SETUP_SHORT_MS = 2500,
  parameter int unsigned SETUP_MID_MS   = 7500,
  parameter int unsigned SETUP_LONG_MS  = 12500,
  parameter bit          OUT2_LONG      = 1'b0,
  parameter int unsigned OUT2_SHORT_MS  = 210,
  parameter int unsigned OUT2_LONG_MS   = 360,
  parameter int unsigned GAP_MS         = 10,
  parameter int unsigned P1W            = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           btn_a_n,
  input  logic           btn_b_n,
  input  logic [1:0]     delay_sel,
  input  logic           uv_flag,
  input  logic [P1W-1:0] pulse1_len,
  output logic           rst_hi,
  output logic           rst_lo_n
);
  localparam int unsigned DIV     = CLK_HZ / TICK_HZ;
  localparam int unsigned OUT2_MS = OUT2_LONG ? OUT2_LONG_MS : OUT2_SHORT_MS;
  localparam int unsigned FIX_MAX = maxu(maxu(maxu(SETUP_SHORT_MS, SETUP_MID_MS), SETUP_LONG_MS),
                                         maxu(OUT2_MS, GAP_MS));
  localparam int unsigned CW      = maxu(P1W, $clog2(FIX_MAX + 1));

  logic       tick;
  logic       fire;
  logic [1:0] sel_q;
  logic       act1, act2, idle1, idle2;

  // strap code is taken while reset is held and frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= delay_sel;
  end

  lpr_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  lpr_qualify #(
    .CW      (CW),
    .SHORT_MS(SETUP_SHORT_MS),
    .MID_MS  (SETUP_MID_MS),
    .LONG_MS (SETUP_LONG_MS)
  ) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .btn_a_n (btn_a_n),
    .btn_b_n (btn_b_n),
    .sel_code(sel_q),
    .fire    (fire)
  );

  lpr_stretch #(.CW(CW), .GAP_MS(GAP_MS)) u_out1 (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .hold (uv_flag),
    .trig (fire),
    .len  (CW'(pulse1_len)),
    .act  (act1),
    .idle (idle1)
  );

  lpr_stretch #(.CW(CW), .GAP_MS(0)) u_out2 (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .hold (uv_flag),
    .trig (fire),
    .len  (CW'(OUT2_MS)),
    .act  (act2),
    .idle (idle2)
  );

  assign rst_hi   = act1;
  assign rst_lo_n = ~act2;

  AST_JOINT_ASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && idle1 && idle2 && !uv_flag) |=> (rst_hi && !rst_lo_n)); // R3
  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(sel_q)); // R2

endmodule

// File: tb/lpress_rst_gen_test.sv
module lpress_rst_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 4;
  localparam int SET_S = 8, SET_M = 12, SET_L = 16;
  localparam int L2   = 5;
  localparam int GAP  = 20;

  logic       clk = 1'b0;
  logic       rst_n, btn_a_n, btn_b_n, uv_flag;
  logic [1:0] delay_sel;
  logic [7:0] pulse1_len;
  logic       rst_hi, rst_lo_n;

  int total = 0, bad = 0;
  int t, hi_rise, hi_rise2, hi_fall, hi_rises, lo_on, lo_on2, lo_off, lo_ons;
  logic lo_at_hi_rise, hi_at_lo_on2, prev_hi, prev_lo;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpress_rst_gen #(
    .CLK_HZ(4000), .TICK_HZ(1000),
    .SETUP_SHORT_MS(SET_S), .SETUP_MID_MS(SET_M), .SETUP_LONG_MS(SET_L),
    .OUT2_LONG(1'b0), .OUT2_SHORT_MS(L2), .OUT2_LONG_MS(9),
    .GAP_MS(GAP), .P1W(8)
  ) uut (
    .clk(clk), .rst_n(rst_n), .btn_a_n(btn_a_n), .btn_b_n(btn_b_n),
    .delay_sel(delay_sel), .uv_flag(uv_flag), .pulse1_len(pulse1_len),
    .rst_hi(rst_hi), .rst_lo_n(rst_lo_n)
  );

  function automatic int setup_of(input logic [1:0] s);
    if (s[1]) return SET_L;
    if (s[0]) return SET_M;
    return SET_S;
  endfunction

  function automatic int eff_len(input int l);
    return (l == 0) ? 1 : l;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_win(input string req, input int v, input int lo, input int hi);
    total++;
    if (v < lo || v > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, v, lo, hi);
    end
  endtask

  task automatic obs_clear();
    t = 0; hi_rise = -1; hi_rise2 = -1; hi_fall = -1; hi_rises = 0;
    lo_on = -1; lo_on2 = -1; lo_off = -1; lo_ons = 0;
    lo_at_hi_rise = 1'b0; hi_at_lo_on2 = 1'b1;
    prev_hi = rst_hi; prev_lo = !rst_lo_n;
  endtask

  task automatic obs(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      t++;
      if (rst_hi && !prev_hi) begin
        hi_rises++;
        if (hi_rise < 0) begin hi_rise = t; lo_at_hi_rise = !rst_lo_n; end
        else if (hi_rise2 < 0) hi_rise2 = t;
      end
      if (!rst_hi && prev_hi && hi_fall < 0) hi_fall = t;
      if (!rst_lo_n && !prev_lo) begin
        lo_ons++;
        if (lo_on < 0) lo_on = t;
        else if (lo_on2 < 0) begin lo_on2 = t; hi_at_lo_on2 = rst_hi; end
      end
      if (rst_lo_n && prev_lo && lo_off < 0) lo_off = t;
      prev_hi = rst_hi; prev_lo = !rst_lo_n;
    end
  endtask

  task automatic settle();
    obs(GAP*DIV + 8);
  endtask

  task automatic do_reset(input logic [1:0] sel, input int l1);
    @(negedge clk);
    rst_n = 1'b0; btn_a_n = 1'b1; btn_b_n = 1'b1; uv_flag = 1'b0;
    delay_sel = sel; pulse1_len = 8'(l1);
    repeat (4) @(negedge clk);
    check(rst_hi == 1'b1, "R7 rst_hi active in reset", int'(rst_hi), 1);
    check(rst_lo_n == 1'b0, "R4 R7 rst_lo_n low in reset", int'(rst_lo_n), 0);
    obs_clear();
    rst_n = 1'b1;
    obs(60);
    chk_win("R7 rst_hi release after reset", hi_fall, (eff_len(l1)-1)*DIV, eff_len(l1)*DIV+3);
    chk_win("R7 rst_lo_n release after reset", lo_off, (L2-1)*DIV, L2*DIV+3);
    settle();
  endtask

  task automatic long_press(input int tgt, input int l1, input int extra,
                            input bit single, input string req);
    obs_clear();
    btn_a_n = 1'b0;
    if (!single) btn_b_n = 1'b0;
    obs(tgt*DIV + 6);
    obs(extra);
    btn_a_n = 1'b1;
    if (!single) btn_b_n = 1'b1;
    obs(60);
    chk_win({req, " setup latency"}, hi_rise, (tgt-1)*DIV+2, tgt*DIV+4);
    check(lo_at_hi_rise == 1'b1, "R3 both outputs same cycle", int'(lo_at_hi_rise), 1);
    chk_win("R5 rst_hi width", hi_fall - hi_rise, (eff_len(l1)-1)*DIV, eff_len(l1)*DIV+3);
    chk_win("R5 rst_lo_n width", lo_off - lo_on, (L2-1)*DIV, L2*DIV+3);
    check(hi_rises == 1, "R11 one pulse per press", hi_rises, 1);
    settle();
  endtask

  task automatic short_press(input int tgt, input string req);
    obs_clear();
    btn_a_n = 1'b0; btn_b_n = 1'b0;
    obs((tgt-2)*DIV);
    btn_a_n = 1'b1; btn_b_n = 1'b1;
    obs(8);
    check(hi_rises == 0 && lo_ons == 0, req, hi_rises + lo_ons, 0);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; btn_a_n = 1'b1; btn_b_n = 1'b1; uv_flag = 1'b0;
    delay_sel = 2'b00; pulse1_len = 8'd6;

    // power-on and basic long press (short setup)
    do_reset(2'b00, 6);
    long_press(SET_S, 6, 0, 1'b0, "R1 R2 R10 short sel");

    // buttons kept held long after the pulse: single reset only
    long_press(SET_S, 6, 3*SET_S*DIV, 1'b0, "R11 held");

    // two short presses separated by a release never qualify
    obs_clear();
    btn_a_n = 1'b0; btn_b_n = 1'b0; obs((SET_S-2)*DIV);
    btn_a_n = 1'b1; btn_b_n = 1'b1; obs(3);
    btn_a_n = 1'b0; btn_b_n = 1'b0; obs((SET_S-2)*DIV);
    btn_a_n = 1'b1; btn_b_n = 1'b1; obs(8);
    check(hi_rises == 0 && lo_ons == 0, "R1 release restarts count", hi_rises, 0);

    // second input tied low: first button alone qualifies
    btn_b_n = 1'b0; obs(4);
    long_press(SET_S, 6, 0, 1'b1, "R8 single button");
    btn_b_n = 1'b1; obs(4);

    // undervoltage forces and stretches both outputs
    obs_clear();
    uv_flag = 1'b1;
    obs(1);
    check(rst_hi == 1'b1 && rst_lo_n == 1'b0, "R6 uv forces outputs", int'(rst_lo_n), 0);
    obs(10);
    check(rst_hi == 1'b1 && rst_lo_n == 1'b0, "R6 uv keeps outputs", int'(rst_hi), 1);
    uv_flag = 1'b0;
    obs_clear();
    obs(60);
    chk_win("R6 rst_hi stretch after uv", hi_fall, 5*DIV, 6*DIV+3);
    chk_win("R6 rst_lo_n stretch after uv", lo_off, (L2-1)*DIV, L2*DIV+3);
    settle();

    // the other select codes
    do_reset(2'b01, 3);
    long_press(SET_M, 3, 0, 1'b0, "R2 mid sel");
    do_reset(2'b10, 7);
    long_press(SET_L, 7, 0, 1'b0, "R2 long sel");
    do_reset(2'b11, 2);
    long_press(SET_L, 2, 0, 1'b0, "R2 code 11 long");

    // second press lands in the quiet gap of rst_hi
    do_reset(2'b00, 4);
    obs_clear();
    btn_a_n = 1'b0; btn_b_n = 1'b0;
    obs(SET_S*DIV + 6);
    btn_a_n = 1'b1; btn_b_n = 1'b1;
    obs(3);
    btn_a_n = 1'b0; btn_b_n = 1'b0;
    obs(SET_S*DIV + 6);
    btn_a_n = 1'b1; btn_b_n = 1'b1;
    obs(GAP*DIV + 20);
    check(lo_ons == 2, "R9 second trigger reached rst_lo_n", lo_ons, 2);
    check(hi_at_lo_on2 == 1'b0, "R9 rst_hi held off in gap", int'(hi_at_lo_on2), 0);
    check(hi_rises == 2, "R9 held request served", hi_rises, 2);
    chk_win("R9 gap length", hi_rise2 - hi_fall, (GAP-1)*DIV, GAP*DIV+4);
    settle();

    // constrained random trials
    for (int k = 0; k < 8; k++) begin
      logic [1:0] s;
      int l1;
      s  = 2'($urandom % 4);
      l1 = int'($urandom % 10);
      do_reset(s, l1);
      if ($urandom % 2 == 0) long_press(setup_of(s), l1, int'($urandom % 20), 1'b0, "R1 R2 random");
      else short_press(setup_of(s), "R1 random short press ignored");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule